// File: doc/BRIEF.md
# Toeplitz Flow Hash Engine

This block turns a flow identifier into a 32-bit Toeplitz hash and then into a table slot number. A 320-bit secret key is written ahead of time, one 32-bit word at a time, through a small write port. A flow is presented as a source address (128 bits), a destination address (128 bits), two 16-bit port numbers and an 8-bit protocol value. The engine packs these fields into a fixed 40-byte stream and hashes that stream one byte per clock. It does this by sliding a window over the key, which has first been moved up by five bit places.

A caller pulses `start` with the flow fields. The engine then stays busy for one cycle per byte. After that it raises `done`, together with the hash and the slot number, which is the hash moved down by twelve places and masked to the table size. The results stay in place until the next accepted start. Key writes and new starts that arrive during a computation are dropped, so a hash is always computed with a single, consistent key.

Top module: `flow_hash_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `hash` and `index` are all zeros.
- R2: A key write with `key_wr_en` high and `busy` low stores `key_wr_data` into word `key_wr_addr` of the key. Word 0 holds key bits 319:288, and each higher address holds the next lower 32 bits. Addresses 10 to 15 are ignored.
- R3: The effective key is the stored key shifted left by 5 bits, with zeros filling its lowest 5 bits. The top 5 stored bits therefore never affect the hash.
- R4: The hashed stream is 320 bits long. Stream bit 0 is its most significant bit. From the top, the stream holds: the source address, the destination address, the destination port, the source port, 24 zero bits, and then the protocol.
- R5: The hash is the XOR, over every stream bit n that is set, of bits [319-n : 288-n] of the effective key. Key positions below bit 0 count as zero.
- R6: `index` equals bits [21:12] of `hash`, which is (hash >> 12) & (1024-1) with the default 1024-entry table.
- R7: A start seen while not busy is accepted on that clock edge. `busy` is then high for exactly 40 cycles, and `done` rises on the edge at which `busy` falls.
- R8: After completion, `done`, `hash` and `index` hold their values until the next accepted start. `done` falls on the edge that accepts that start. `busy` and `done` are never high together.
- R9: A start pulse during a computation is ignored, and the running result is unaffected.
- R10: A key write during a computation is ignored, and the stored key keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr_en | input | 1 | Key word write strobe |
| key_wr_addr | input | 4 | Key word number, 0 = most significant |
| key_wr_data | input | 32 | Key word value |
| start | input | 1 | Begin hashing the presented flow |
| src_addr | input | 128 | Source address |
| dst_addr | input | 128 | Destination address |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| l4_proto | input | 8 | Transport protocol number |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid |
| hash | output | 32 | Toeplitz hash result |
| index | output | 10 | Table slot derived from the hash |

## Verification
The assertions check the control behaviour on every cycle. They check that `busy` and `done` are never high together, that an accepted start always sets `busy` and clears `done`, and that the step counter advances by exactly one while `busy` is high. They also check that `done` only rises after the final step, that a held result stays unchanged, and that the stored key does not move when a write arrives during a computation. Only the bench scenarios can show that the hash values are correct. The bench compares them against a bit-serial reference under random and hand-picked keys and tuples. It also covers the key-word ordering, the five-bit key shift and the field packing, and it shows at the result ports that dropped writes and dropped starts had no effect.

// File: rtl/fhash_pkg.sv
package fhash_pkg;

   // Control state of the hashing datapath
   typedef enum logic {
      FH_IDLE = 1'b0,
      FH_RUN  = 1'b1
   } fhash_state_e;

   // Bits consumed from the stream per lane
   localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/fhash_key_store.sv
module fhash_key_store #(
   parameter int unsigned KEY_WORDS    = 10,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned KEY_PRESHIFT = 5,
   parameter int unsigned KA_W         = 4,
   localparam int unsigned KEY_BITS    = KEY_WORDS * WORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [KA_W-1:0]     wr_addr,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                lock,
   output logic [KEY_BITS-1:0] eff_key
);

   if (KEY_PRESHIFT >= WORD_W) begin : g_bad_shift
      $error("fhash_key_store: pre-shift must be below one word");
   end
   if ((1 << KA_W) < KEY_WORDS) begin : g_bad_addr
      $error("fhash_key_store: address too narrow for key words");
   end

   logic [KEY_BITS-1:0] key_flat;

   // One register per key word; word 0 is the most significant
   for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && !lock && (wr_addr == KA_W'(w))) begin
            word_q <= wr_data;
         end
      end
      assign key_flat[KEY_BITS-1-w*WORD_W -: WORD_W] = word_q;
   end

   // Drop the top bits; zeros enter at the bottom
   assign eff_key = key_flat << KEY_PRESHIFT;

   // R10: stored key is frozen while the datapath runs
   p_key_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock) |=> $stable(key_flat))
      else $error("key changed during a locked write");

endmodule

// File: rtl/fhash_tuple_pack.sv
module fhash_tuple_pack #(
   parameter int unsigned ADDR_W   = 128,
   parameter int unsigned PORT_W   = 16,
   parameter int unsigned PROTO_W  = 8,
   parameter int unsigned WORD_W   = 32,
   localparam int unsigned STREAM_BITS = 2 * ADDR_W + 2 * WORD_W
) (
   input  logic [ADDR_W-1:0]      src_addr,
   input  logic [ADDR_W-1:0]      dst_addr,
   input  logic [PORT_W-1:0]      src_port,
   input  logic [PORT_W-1:0]      dst_port,
   input  logic [PROTO_W-1:0]     l4_proto,
   output logic [STREAM_BITS-1:0] stream
);

   if (2 * PORT_W != WORD_W) begin : g_bad_ports
      $error("fhash_tuple_pack: two ports must fill one word");
   end
   if (PROTO_W > WORD_W) begin : g_bad_proto
      $error("fhash_tuple_pack: protocol wider than a word");
   end
   if (ADDR_W % WORD_W != 0) begin : g_bad_addr
      $error("fhash_tuple_pack: address not a whole number of words");
   end

   logic [WORD_W-1:0] port_word;
   logic [WORD_W-1:0] proto_word;

   assign port_word  = {dst_port, src_port};
   assign proto_word = WORD_W'(l4_proto);
   assign stream     = {src_addr, dst_addr, port_word, proto_word};

endmodule

// File: rtl/fhash_core.sv
module fhash_core
   import fhash_pkg::*;
#(
   parameter int unsigned KEY_BITS       = 320,
   parameter int unsigned HASH_W         = 32,
   parameter int unsigned STREAM_BITS    = 320,
   parameter int unsigned BYTES_PER_STEP = 1,
   parameter int unsigned IDX_SHIFT      = 12,
   parameter int unsigned IDX_W          = 10,
   localparam int unsigned STEP_BITS     = LANE_BITS * BYTES_PER_STEP,
   localparam int unsigned NSTEPS        = STREAM_BITS / STEP_BITS,
   localparam int unsigned CNT_W         = $clog2(NSTEPS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [KEY_BITS-1:0]    eff_key,
   input  logic [STREAM_BITS-1:0] stream,
   output logic                   busy,
   output logic                   done,
   output logic [HASH_W-1:0]      hash,
   output logic [IDX_W-1:0]       index
);

   if (STREAM_BITS % STEP_BITS != 0) begin : g_bad_step
      $error("fhash_core: stream not a whole number of steps");
   end
   if (STEP_BITS + HASH_W > KEY_BITS) begin : g_bad_key
      $error("fhash_core: key shorter than one step window");
   end
   if (IDX_SHIFT + IDX_W > HASH_W) begin : g_bad_idx
      $error("fhash_core: index field outside the hash");
   end

   fhash_state_e             state_q;
   logic [KEY_BITS-1:0]      ksr_q;
   logic [STREAM_BITS-1:0]   str_q;
   logic [HASH_W-1:0]        acc_q;
   logic [HASH_W-1:0]        hash_q;
   logic [CNT_W-1:0]         cnt_q;
   logic                     done_q;
   logic [HASH_W-1:0]        term;

   // Each set stream bit k of this step adds the window moved up by k
   always_comb begin
      term = '0;
      for (int k = 0; k < STEP_BITS; k++) begin
         if (str_q[STREAM_BITS-1-k]) begin
            term = term ^ ksr_q[KEY_BITS-1-k -: HASH_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FH_IDLE;
         ksr_q   <= '0;
         str_q   <= '0;
         acc_q   <= '0;
         hash_q  <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         case (state_q)
            FH_IDLE: begin
               if (start) begin
                  state_q <= FH_RUN;
                  ksr_q   <= eff_key;
                  str_q   <= stream;
                  acc_q   <= '0;
                  cnt_q   <= '0;
                  done_q  <= 1'b0;
               end
            end
            FH_RUN: begin
               acc_q <= acc_q ^ term;
               ksr_q <= ksr_q << STEP_BITS;
               str_q <= str_q << STEP_BITS;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(NSTEPS - 1)) begin
                  state_q <= FH_IDLE;
                  done_q  <= 1'b1;
                  hash_q  <= acc_q ^ term;
               end
            end
            default: state_q <= FH_IDLE;
         endcase
      end
   end

   assign busy  = (state_q == FH_RUN);
   assign done  = done_q;
   assign hash  = hash_q;
   assign index = hash_q[IDX_SHIFT +: IDX_W];

   // R8: busy and done are mutually exclusive
   p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done))
      else $error("busy and done both high");

   // R7: an idle start is always taken
   p_start_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done))
      else $error("start not accepted");

   // R9: while running, the step counter only moves forward by one
   p_step_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || (cnt_q == $past(cnt_q) + 1'b1)))
      else $error("step counter disturbed during run");

   // R7: done rises only after the last step
   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(busy) && ($past(cnt_q) == CNT_W'(NSTEPS - 1))))
      else $error("done raised early");

   // R8: result held while no new start arrives
   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(hash)))
      else $error("result not held");

endmodule

// File: rtl/flow_hash_engine.sv
module flow_hash_engine #(
   parameter int unsigned KEY_WORDS      = 10,
   parameter int unsigned WORD_W         = 32,
   parameter int unsigned KEY_PRESHIFT   = 5,
   parameter int unsigned ADDR_W         = 128,
   parameter int unsigned PORT_W         = 16,
   parameter int unsigned PROTO_W        = 8,
   parameter int unsigned HASH_W         = 32,
   parameter int unsigned IDX_SHIFT      = 12,
   parameter int unsigned TABLE_ENTRIES  = 1024,
   parameter int unsigned BYTES_PER_STEP = 1,
   localparam int unsigned KA_W          = $clog2(KEY_WORDS),
   localparam int unsigned KEY_BITS      = KEY_WORDS * WORD_W,
   localparam int unsigned STREAM_BITS   = 2 * ADDR_W + 2 * WORD_W,
   localparam int unsigned IDX_W         = $clog2(TABLE_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_wr_en,
   input  logic [KA_W-1:0]    key_wr_addr,
   input  logic [WORD_W-1:0]  key_wr_data,
   input  logic               start,
   input  logic [ADDR_W-1:0]  src_addr,
   input  logic [ADDR_W-1:0]  dst_addr,
   input  logic [PORT_W-1:0]  src_port,
   input  logic [PORT_W-1:0]  dst_port,
   input  logic [PROTO_W-1:0] l4_proto,
   output logic               busy,
   output logic               done,
   output logic [HASH_W-1:0]  hash,
   output logic [IDX_W-1:0]   index
);

   if ((1 << IDX_W) != TABLE_ENTRIES) begin : g_bad_table
      $error("flow_hash_engine: table size must be a power of two");
   end
   if (STREAM_BITS > KEY_BITS) begin : g_bad_len
      $error("flow_hash_engine: stream longer than key");
   end
   if (BYTES_PER_STEP == 0) begin : g_bad_lanes
      $error("flow_hash_engine: at least one byte per step");
   end

   logic [KEY_BITS-1:0]    eff_key;
   logic [STREAM_BITS-1:0] stream;

   fhash_key_store #(
      .KEY_WORDS    (KEY_WORDS),
      .WORD_W       (WORD_W),
      .KEY_PRESHIFT (KEY_PRESHIFT),
      .KA_W         (KA_W)
   ) u_keys (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (key_wr_en),
      .wr_addr (key_wr_addr),
      .wr_data (key_wr_data),
      .lock    (busy),
      .eff_key (eff_key)
   );

   fhash_tuple_pack #(
      .ADDR_W  (ADDR_W),
      .PORT_W  (PORT_W),
      .PROTO_W (PROTO_W),
      .WORD_W  (WORD_W)
   ) u_pack (
      .src_addr (src_addr),
      .dst_addr (dst_addr),
      .src_port (src_port),
      .dst_port (dst_port),
      .l4_proto (l4_proto),
      .stream   (stream)
   );

   fhash_core #(
      .KEY_BITS       (KEY_BITS),
      .HASH_W         (HASH_W),
      .STREAM_BITS    (STREAM_BITS),
      .BYTES_PER_STEP (BYTES_PER_STEP),
      .IDX_SHIFT      (IDX_SHIFT),
      .IDX_W          (IDX_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .eff_key (eff_key),
      .stream  (stream),
      .busy    (busy),
      .done    (done),
      .hash    (hash),
      .index   (index)
   );

endmodule

// File: tb/flow_hash_engine_test.sv
`timescale 1ns/1ps
module flow_hash_engine_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         key_wr_en = 1'b0;
   logic [3:0]   key_wr_addr = '0;
   logic [31:0]  key_wr_data = '0;
   logic         start = 1'b0;
   logic [127:0] src_addr = '0;
   logic [127:0] dst_addr = '0;
   logic [15:0]  src_port = '0;
   logic [15:0]  dst_port = '0;
   logic [7:0]   l4_proto = '0;
   logic         busy;
   logic         done;
   logic [31:0]  hash;
   logic [9:0]   index;

   int n_checks = 0;
   int n_fail = 0;

   logic [319:0] cur_key;

   always #2.5 clk = ~clk;

   flow_hash_engine uut (
      .clk(clk), .rst_n(rst_n),
      .key_wr_en(key_wr_en), .key_wr_addr(key_wr_addr), .key_wr_data(key_wr_data),
      .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
      .src_port(src_port), .dst_port(dst_port), .l4_proto(l4_proto),
      .busy(busy), .done(done), .hash(hash), .index(index)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Bit-serial reference built from R3, R4, R5
   function automatic logic [31:0] ref_hash(input logic [319:0] key,
         input logic [127:0] sa, input logic [127:0] da,
         input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] pr);
      logic [319:0] eff;
      logic [351:0] ext;
      logic [319:0] st;
      logic [31:0]  h;
      eff = key << 5;
      ext = {eff, 32'h0};
      st  = {sa, da, dp, sp, 24'h0, pr};
      h   = '0;
      for (int n = 0; n < 320; n++) begin
         if (st[319-n]) h = h ^ ext[351-n -: 32];
      end
      return h;
   endfunction

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [319:0] rnd320();
      logic [319:0] v;
      for (int i = 0; i < 10; i++) v[319-32*i -: 32] = $urandom;
      return v;
   endfunction

   task automatic write_word(input logic [3:0] a, input logic [31:0] d);
      key_wr_en = 1'b1; key_wr_addr = a; key_wr_data = d;
      @(negedge clk);
      key_wr_en = 1'b0;
   endtask

   // R2: word 0 carries key bits 319:288
   task automatic load_key(input logic [319:0] k);
      for (int i = 0; i < 10; i++) write_word(4'(i), k[319-32*i -: 32]);
      cur_key = k;
   endtask

   task automatic set_tuple(input logic [127:0] sa, input logic [127:0] da,
         input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] pr);
      src_addr = sa; dst_addr = da; src_port = sp; dst_port = dp; l4_proto = pr;
   endtask

   // Pulse start, wait for done, return busy length
   task automatic run_hash(output int busy_cycles);
      int guard;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      busy_cycles = 0;
      guard = 0;
      while (busy && guard < 1000) begin
         busy_cycles++; guard++;
         @(negedge clk);
      end
   endtask

   task automatic hash_and_compare(input string req);
      int bc;
      logic [31:0] e;
      e = ref_hash(cur_key, src_addr, dst_addr, src_port, dst_port, l4_proto);
      run_hash(bc);
      check(done === 1'b1, req, 32'(done), 32'd1);
      check(hash === e, req, hash, e);
      check(index === e[21:12], "R6", 32'(index), 32'(e[21:12]));
   endtask

   task automatic t_reset();
      check(busy === 1'b0, "R1 busy", 32'(busy), 0);
      check(done === 1'b0, "R1 done", 32'(done), 0);
      check(hash === 32'h0, "R1 hash", hash, 0);
      check(index === 10'h0, "R1 index", 32'(index), 0);
   endtask

   task automatic t_zero_key();
      load_key('0);
      set_tuple(rnd128(), rnd128(), 16'h1234, 16'h5678, 8'd6);
      hash_and_compare("R5 zero key");
      check(hash === 32'h0, "R5 zero key hash", hash, 0);
   endtask

   task automatic t_preshift();
      logic [319:0] k;
      // Only the top five stored bits set: effective key is empty (R3)
      k = '0; k[319:315] = 5'h1f;
      load_key(k);
      set_tuple({128{1'b1}}, {128{1'b1}}, 16'hffff, 16'hffff, 8'hff);
      hash_and_compare("R3 top bits dropped");
      check(hash === 32'h0, "R3 top bits", hash, 0);
      // Stored bit 314 lands at effective bit 319; first stream bit alone
      k = '0; k[314] = 1'b1;
      load_key(k);
      set_tuple({1'b1, 127'h0}, '0, '0, '0, '0);
      hash_and_compare("R5 first bit");
      check(hash === 32'h8000_0000, "R3 R5 single bit", hash, 32'h8000_0000);
   endtask

   task automatic t_packing();
      load_key(rnd320());
      set_tuple('0, '0, 16'h0, 16'h0, 8'h01);
      hash_and_compare("R4 protocol only");
      set_tuple('0, '0, 16'hbeef, 16'h0, 8'h00);
      hash_and_compare("R4 source port only");
      set_tuple('0, '0, 16'h0, 16'hbeef, 8'h00);
      hash_and_compare("R4 destination port only");
      set_tuple('0, 128'h1, '0, '0, '0);
      hash_and_compare("R4 destination address low bit");
   endtask

   task automatic t_random();
      for (int r = 0; r < 8; r++) begin
         load_key(rnd320());
         set_tuple(rnd128(), rnd128(), 16'($urandom), 16'($urandom), 8'($urandom));
         hash_and_compare("R5 random");
      end
   endtask

   task automatic t_timing();
      int bc;
      set_tuple(rnd128(), rnd128(), 16'h0050, 16'h1f90, 8'd17);
      run_hash(bc);
      check(bc == 40, "R7 busy length", 32'(bc), 32'd40);
      check(done === 1'b1, "R7 done at end", 32'(done), 1);
   endtask

   task automatic t_hold();
      logic [31:0] h0;
      h0 = hash;
      repeat (10) @(negedge clk);
      check(done === 1'b1, "R8 done held", 32'(done), 1);
      check(hash === h0, "R8 hash held", hash, h0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done === 1'b0, "R8 done cleared", 32'(done), 0);
      while (busy) @(negedge clk);
   endtask

   task automatic t_start_busy();
      logic [31:0] e;
      int guard;
      set_tuple(rnd128(), rnd128(), 16'h0101, 16'h0202, 8'd6);
      e = ref_hash(cur_key, src_addr, dst_addr, src_port, dst_port, l4_proto);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      set_tuple(rnd128(), rnd128(), 16'h0303, 16'h0404, 8'd17);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      guard = 0;
      while (busy && guard < 1000) begin guard++; @(negedge clk); end
      check(hash === e, "R9 start during run ignored", hash, e);
   endtask

   task automatic t_write_busy();
      logic [31:0] e;
      int guard;
      set_tuple(rnd128(), rnd128(), 16'h0a0a, 16'h0b0b, 8'd6);
      e = ref_hash(cur_key, src_addr, dst_addr, src_port, dst_port, l4_proto);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      write_word(4'd0, ~cur_key[319:288]);
      write_word(4'd9, ~cur_key[31:0]);
      guard = 0;
      while (busy && guard < 1000) begin guard++; @(negedge clk); end
      check(hash === e, "R10 running hash", hash, e);
      // A fresh run with the same tuple must still use the old key
      hash_and_compare("R10 key unchanged");
   endtask

   task automatic t_bad_addr();
      write_word(4'd10, 32'hdead_beef);
      write_word(4'd15, 32'hcafe_f00d);
      set_tuple(rnd128(), rnd128(), 16'h1111, 16'h2222, 8'd1);
      hash_and_compare("R2 high addresses ignored");
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      cur_key = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_key();
      t_preshift();
      t_packing();
      t_random();
      t_timing();
      t_hold();
      t_start_busy();
      t_write_busy();
      t_bad_addr();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule